// File: doc/BRIEF.md
# MSI Event Queue Router

The router takes message-signalled interrupts, each identified by a number. For every arriving number it consults a per-number routing entry. If the entry allows it, the router stores one record in a circular event queue that sits in system memory. There are several queues, normally one per processor. Each queue has a tail pointer that hardware advances, a head pointer that software advances, an enable, a sticky overflow flag and a dedicated interrupt line.

After a number has produced a record, it is held as pending and cannot produce another. Software re-arms it through a clear register once it has handled the event. Software configures routing entries, queue pointers, queue enables and the common memory base through a 64-bit register port. Register reads return data one cycle after the read strobe. Records leave the block on a single-beat memory write port, one cycle after the message that caused them.

Top module: `msiq_router`

## Requirements
- R1: Each message number n has a routing entry at register offset 0x0000 + 8n. A write sets the valid flag from bit 63 and the target queue from bits 5:0. A read returns valid in bit 63, pending in bit 62 and the target queue in bits 5:0, with every other bit zero. Any register read returns its data in the cycle after the read strobe.
- R2: A message is accepted only when all of the following hold: its entry is valid, its pending flag is clear, its target queue index is below the queue count, and that queue is enabled. Any other message produces no memory write and changes no queue pointer.
- R3: An accepted message causes exactly one memory write in the next cycle. The write address is base + q·DEPTH·REC_BYTES + tail·REC_BYTES. The data carries type 0x01 in bits 63:56 and the message number zero-extended in bits 31:0. The queue's tail then advances by one and the message's pending flag is set.
- R4: A pending message is dropped until software writes its clear register (offset 0x1000 + 8n) with bit 62 set. After that write, the message can be queued again.
- R5: A message whose queue is full is dropped. A queue is full when tail + 1 equals head, modulo the depth. The drop leaves the pending flag clear and sets a sticky overflow flag in bit 0 of the queue's state register (0x2400 + 8q). Only a control-clear write with bit 0 set clears that flag.
- R6: Writing bit 44 to the control-set register (0x2000 + 8q) enables queue q. Writing bit 44 to the control-clear register (0x2200 + 8q) disables it. State register bit 44 reflects the enable.
- R7: Tail (0x2600 + 8q) and head (0x2800 + 8q) are software-readable and software-writable. Both wrap modulo the queue depth.
- R8: Interrupt line q is high exactly while queue q is enabled and its head differs from its tail.
- R9: After reset, no entry is valid and nothing is pending. All queues are disabled, with zero pointers and clear overflow. No interrupt is raised and no memory write is issued.
- R10: The queue memory base is a 64-bit register at offset 0x2A00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | An interrupt message is present this cycle |
| msi_num | input | MSI_W | Number of the incoming message |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RA_W | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, valid the cycle after reg_rd |
| mem_wr_valid | output | 1 | Record write to memory |
| mem_wr_addr | output | 64 | Record byte address |
| mem_wr_data | output | 64 | Record contents |
| eq_irq | output | NUM_EQ | One interrupt line per queue |

## Verification
The hardest state to reach is a full queue whose tail then wraps past the end of the ring. Reaching it from the ports takes a run of accepted messages, and each one first needs its pending flag re-armed through the clear register. The bench uses a four-entry queue. It fills queue 0 with three records and checks that the fourth is dropped with overflow set and pending left clear. It then moves the head by register write and sends one more record into the last slot. Finally it reads the tail back as zero. The table-driven phase exercises every reason a message can be refused: invalid entry, pending, disabled queue and an out-of-range queue index.

// File: rtl/msiq_pkg.sv
package msiq_pkg;
   localparam int REG_W        = 64;
   localparam int MAP_V_BIT    = 63;
   localparam int MAP_P_BIT    = 62;
   localparam int EN_BIT       = 44;
   localparam int QSEL_W       = 6;
   localparam logic [7:0] REC_TYPE = 8'h01;

   typedef struct packed {
      logic              valid;
      logic              pend;
      logic [QSEL_W-1:0] qsel;
   } map_ent_t;
endpackage

// File: rtl/msiq_map_table.sv
module msiq_map_table
   import msiq_pkg::*;
#(
   parameter int NUM_MSI = 256,
   localparam int MSI_W  = $clog2(NUM_MSI)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MSI_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic [QSEL_W-1:0] wr_qsel,
   input  logic              clr_en,
   input  logic [MSI_W-1:0]  clr_idx,
   input  logic              set_pend,
   input  logic [MSI_W-1:0]  set_idx,
   input  logic [MSI_W-1:0]  lk_idx,
   output map_ent_t          lk_ent,
   input  logic [MSI_W-1:0]  rd_idx,
   output map_ent_t          rd_ent
);
   map_ent_t tbl [NUM_MSI];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_MSI; i++) tbl[i] <= '0;
      end else begin
         if (wr_en) begin
            tbl[wr_idx].valid <= wr_valid;
            tbl[wr_idx].qsel  <= wr_qsel;
         end
         if (clr_en)   tbl[clr_idx].pend <= 1'b0;
         if (set_pend) tbl[set_idx].pend <= 1'b1;
      end
   end

   assign lk_ent = tbl[lk_idx];
   assign rd_ent = tbl[rd_idx];
endmodule

// File: rtl/msiq_queue_ctl.sv
module msiq_queue_ctl #(
   parameter int DEPTH  = 256,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_set,
   input  logic             en_clr,
   input  logic             ovf_clr,
   input  logic             head_wr,
   input  logic             tail_wr,
   input  logic [PTR_W-1:0] ptr_wdata,
   input  logic             push_req,
   output logic             en_o,
   output logic             ovf_o,
   output logic [PTR_W-1:0] head_o,
   output logic [PTR_W-1:0] tail_o,
   output logic             push_ok,
   output logic             irq
);
   logic             en, ovf, full;
   logic [PTR_W-1:0] head, tail, tail_nx;

   assign tail_nx = tail + PTR_W'(1);
   assign full    = (tail_nx == head);
   assign push_ok = push_req && en && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= 1'b0;
         ovf  <= 1'b0;
         head <= '0;
         tail <= '0;
      end else begin
         if (en_clr)      en <= 1'b0;
         else if (en_set) en <= 1'b1;
         if (ovf_clr) ovf <= 1'b0;
         if (push_req && en && full) ovf <= 1'b1;
         if (head_wr) head <= ptr_wdata;
         if (tail_wr)      tail <= ptr_wdata;
         else if (push_ok) tail <= tail_nx;
      end
   end

   assign irq    = en && (head != tail);
   assign en_o   = en;
   assign ovf_o  = ovf;
   assign head_o = head;
   assign tail_o = tail;

   AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && !tail_wr) |=> (tail == $past(tail) + PTR_W'(1))); // R3
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full && !tail_wr) |=> $stable(tail)); // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf); // R5
   AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (head == tail) |-> !irq); // R8
endmodule

// File: rtl/msiq_rec_writer.sv
module msiq_rec_writer
   import msiq_pkg::*;
#(
   parameter int NUM_EQ    = 4,
   parameter int DEPTH     = 256,
   parameter int REC_BYTES = 64,
   parameter int MSI_W     = 8,
   localparam int QW       = (NUM_EQ > 1) ? $clog2(NUM_EQ) : 1,
   localparam int PTR_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [QW-1:0]    qidx,
   input  logic [PTR_W-1:0] slot,
   input  logic [MSI_W-1:0] msi,
   input  logic [63:0]      base,
   output logic             wr_valid,
   output logic [63:0]      wr_addr,
   output logic [63:0]      wr_data
);
   localparam int REC_SH = $clog2(REC_BYTES);
   localparam int Q_SH   = $clog2(DEPTH * REC_BYTES);

   if ((1 << REC_SH) != REC_BYTES || REC_BYTES < 8) begin : g_bad_rec
      $error("REC_BYTES must be a power of two of at least 8");
   end

   logic [63:0] addr_nx, data_nx;
   assign addr_nx = base + (64'(qidx) << Q_SH) + (64'(slot) << REC_SH);
   assign data_nx = {REC_TYPE, 24'h0, 32'(msi)};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= go;
         if (go) begin
            wr_addr <= addr_nx;
            wr_data <= data_nx;
         end
      end
   end
endmodule

// File: rtl/msiq_router.sv
module msiq_router
   import msiq_pkg::*;
#(
   parameter int NUM_MSI   = 256,
   parameter int NUM_EQ    = 4,
   parameter int EQ_DEPTH  = 256,
   parameter int REC_BYTES = 64,
   parameter int RA_W      = 16,
   parameter logic [15:0] MAP_OFF   = 16'h0000,
   parameter logic [15:0] CLR_OFF   = 16'h1000,
   parameter logic [15:0] CSET_OFF  = 16'h2000,
   parameter logic [15:0] CCLR_OFF  = 16'h2200,
   parameter logic [15:0] STATE_OFF = 16'h2400,
   parameter logic [15:0] TAIL_OFF  = 16'h2600,
   parameter logic [15:0] HEAD_OFF  = 16'h2800,
   parameter logic [15:0] BASE_OFF  = 16'h2A00,
   localparam int MSI_W = $clog2(NUM_MSI)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msi_valid,
   input  logic [MSI_W-1:0]  msi_num,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   output logic              mem_wr_valid,
   output logic [63:0]       mem_wr_addr,
   output logic [63:0]       mem_wr_data,
   output logic [NUM_EQ-1:0] eq_irq
);
   localparam int QW    = (NUM_EQ > 1) ? $clog2(NUM_EQ) : 1;
   localparam int PTR_W = $clog2(EQ_DEPTH);

   if ((1 << MSI_W) != NUM_MSI) begin : g_bad_msi
      $error("NUM_MSI must be a power of two");
   end
   if ((1 << PTR_W) != EQ_DEPTH || EQ_DEPTH < 2) begin : g_bad_depth
      $error("EQ_DEPTH must be a power of two of at least 2");
   end
   if (NUM_EQ < 1 || NUM_EQ > 64) begin : g_bad_neq
      $error("NUM_EQ must be within 1 to 64");
   end
   if (NUM_MSI * 8 > 32'(CLR_OFF - MAP_OFF) || MSI_W + 3 > RA_W) begin : g_bad_map
      $error("routing entries overlap the clear window");
   end

   // ---------------- register decode ----------------
   logic [RA_W-1:0] d_map, d_clr, d_cset, d_cclr, d_state, d_tail, d_head;
   logic hit_map, hit_clr, hit_cset, hit_cclr, hit_state, hit_tail, hit_head, hit_base;
   logic [MSI_W-1:0] map_idx, clr_idx;
   logic [QW-1:0]    cset_idx, cclr_idx, state_idx, tail_idx, head_idx;
   logic             aligned;

   assign aligned = (reg_addr[2:0] == 3'b000);
   assign d_map   = reg_addr - RA_W'(MAP_OFF);
   assign d_clr   = reg_addr - RA_W'(CLR_OFF);
   assign d_cset  = reg_addr - RA_W'(CSET_OFF);
   assign d_cclr  = reg_addr - RA_W'(CCLR_OFF);
   assign d_state = reg_addr - RA_W'(STATE_OFF);
   assign d_tail  = reg_addr - RA_W'(TAIL_OFF);
   assign d_head  = reg_addr - RA_W'(HEAD_OFF);

   assign hit_map   = aligned && (reg_addr >= RA_W'(MAP_OFF))   && (32'(d_map)   < NUM_MSI * 8);
   assign hit_clr   = aligned && (reg_addr >= RA_W'(CLR_OFF))   && (32'(d_clr)   < NUM_MSI * 8);
   assign hit_cset  = aligned && (reg_addr >= RA_W'(CSET_OFF))  && (32'(d_cset)  < NUM_EQ * 8);
   assign hit_cclr  = aligned && (reg_addr >= RA_W'(CCLR_OFF))  && (32'(d_cclr)  < NUM_EQ * 8);
   assign hit_state = aligned && (reg_addr >= RA_W'(STATE_OFF)) && (32'(d_state) < NUM_EQ * 8);
   assign hit_tail  = aligned && (reg_addr >= RA_W'(TAIL_OFF))  && (32'(d_tail)  < NUM_EQ * 8);
   assign hit_head  = aligned && (reg_addr >= RA_W'(HEAD_OFF))  && (32'(d_head)  < NUM_EQ * 8);
   assign hit_base  = (reg_addr == RA_W'(BASE_OFF));

   assign map_idx   = d_map[MSI_W+2:3];
   assign clr_idx   = d_clr[MSI_W+2:3];
   assign cset_idx  = d_cset[QW+2:3];
   assign cclr_idx  = d_cclr[QW+2:3];
   assign state_idx = d_state[QW+2:3];
   assign tail_idx  = d_tail[QW+2:3];
   assign head_idx  = d_head[QW+2:3];

   // ---------------- routing table ----------------
   map_ent_t lk, rd_ent;
   logic [NUM_EQ-1:0] q_req, q_acc, q_en, q_ovf;
   logic [PTR_W-1:0]  q_head [NUM_EQ];
   logic [PTR_W-1:0]  q_tail [NUM_EQ];
   logic              any_acc;

   assign any_acc = |q_acc;

   msiq_map_table #(.NUM_MSI(NUM_MSI)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr && hit_map),
      .wr_idx   (map_idx),
      .wr_valid (reg_wdata[MAP_V_BIT]),
      .wr_qsel  (reg_wdata[QSEL_W-1:0]),
      .clr_en   (reg_wr && hit_clr && reg_wdata[MAP_P_BIT]),
      .clr_idx  (clr_idx),
      .set_pend (any_acc),
      .set_idx  (msi_num),
      .lk_idx   (msi_num),
      .lk_ent   (lk),
      .rd_idx   (map_idx),
      .rd_ent   (rd_ent)
   );

   // ---------------- queues ----------------
   for (genvar g = 0; g < NUM_EQ; g++) begin : g_q
      assign q_req[g] = msi_valid && lk.valid && !lk.pend && (lk.qsel == QSEL_W'(g));
      msiq_queue_ctl #(.DEPTH(EQ_DEPTH)) u_q (
         .clk       (clk),
         .rst_n     (rst_n),
         .en_set    (reg_wr && hit_cset && cset_idx == QW'(g) && reg_wdata[EN_BIT]),
         .en_clr    (reg_wr && hit_cclr && cclr_idx == QW'(g) && reg_wdata[EN_BIT]),
         .ovf_clr   (reg_wr && hit_cclr && cclr_idx == QW'(g) && reg_wdata[0]),
         .head_wr   (reg_wr && hit_head && head_idx == QW'(g)),
         .tail_wr   (reg_wr && hit_tail && tail_idx == QW'(g)),
         .ptr_wdata (reg_wdata[PTR_W-1:0]),
         .push_req  (q_req[g]),
         .en_o      (q_en[g]),
         .ovf_o     (q_ovf[g]),
         .head_o    (q_head[g]),
         .tail_o    (q_tail[g]),
         .push_ok   (q_acc[g]),
         .irq       (eq_irq[g])
      );
   end

   logic [PTR_W-1:0] sel_tail;
   logic [QW-1:0]    sel_q;
   always_comb begin
      sel_tail = '0;
      sel_q    = '0;
      for (int i = 0; i < NUM_EQ; i++) begin
         if (q_acc[i]) begin
            sel_tail = q_tail[i];
            sel_q    = QW'(i);
         end
      end
   end

   // ---------------- base register ----------------
   logic [63:0] base_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                  base_q <= '0;
      else if (reg_wr && hit_base) base_q <= reg_wdata;
   end

   msiq_rec_writer #(
      .NUM_EQ(NUM_EQ), .DEPTH(EQ_DEPTH), .REC_BYTES(REC_BYTES), .MSI_W(MSI_W)
   ) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (any_acc),
      .qidx     (sel_q),
      .slot     (sel_tail),
      .msi      (msi_num),
      .base     (base_q),
      .wr_valid (mem_wr_valid),
      .wr_addr  (mem_wr_addr),
      .wr_data  (mem_wr_data)
   );

   // ---------------- read mux ----------------
   logic [63:0] rd_nx;
   always_comb begin
      rd_nx = '0;
      if (hit_map) begin
         rd_nx[MAP_V_BIT]     = rd_ent.valid;
         rd_nx[MAP_P_BIT]     = rd_ent.pend;
         rd_nx[QSEL_W-1:0]    = rd_ent.qsel;
      end
      for (int i = 0; i < NUM_EQ; i++) begin
         if (hit_state && state_idx == QW'(i)) begin
            rd_nx[EN_BIT] = q_en[i];
            rd_nx[0]      = q_ovf[i];
         end
         if (hit_tail && tail_idx == QW'(i)) rd_nx = 64'(q_tail[i]);
         if (hit_head && head_idx == QW'(i)) rd_nx = 64'(q_head[i]);
      end
      if (hit_base) rd_nx = base_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_nx;
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(q_acc)); // R2
   AST_INVALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_valid && !lk.valid) |=> !mem_wr_valid); // R2
   AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_valid && lk.pend) |=> !mem_wr_valid); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !msi_valid |=> !mem_wr_valid); // R3
endmodule

// File: tb/test_msiq_router.sv
module test_msiq_router;
   localparam int NM = 16, NQ = 4, DP = 4, RB = 64;
   localparam logic [63:0] BASE = 64'h0000_0000_8000_0000;
   localparam logic [63:0] EN44 = 64'h1 << 44;
   localparam logic [63:0] P62  = 64'h1 << 62;
   localparam logic [63:0] V63  = 64'h1 << 63;

   logic clk = 1'b0, rst_n = 1'b0;
   logic msi_valid = 1'b0;
   logic [3:0] msi_num = '0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [63:0] reg_wdata = '0, reg_rdata, mem_wr_addr, mem_wr_data;
   logic mem_wr_valid;
   logic [NQ-1:0] eq_irq;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   msiq_router #(.NUM_MSI(NM), .NUM_EQ(NQ), .EQ_DEPTH(DP), .REC_BYTES(RB)) i_msiq_router (
      .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_num(msi_num),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .eq_irq(eq_irq));

   // {msi[23:16], expect_write[15], queue[14:8], slot[7:0]}
   localparam logic [23:0] VEC [8] = '{
      {8'd1, 1'b1, 7'd0, 8'd0},
      {8'd2, 1'b1, 7'd1, 8'd0},
      {8'd1, 1'b0, 7'd0, 8'd0},
      {8'd3, 1'b1, 7'd0, 8'd1},
      {8'd4, 1'b0, 7'd0, 8'd0},
      {8'd5, 1'b0, 7'd0, 8'd0},
      {8'd6, 1'b0, 7'd0, 8'd0},
      {8'd7, 1'b1, 7'd2, 8'd0}
   };

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [63:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, output logic [63:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
   endtask

   task automatic send(logic [3:0] n);
      @(negedge clk); msi_valid = 1'b1; msi_num = n;
      @(negedge clk); msi_valid = 1'b0;
   endtask

   function automatic logic [63:0] rec(int n);
      return {8'h01, 24'h0, 32'(n)};
   endfunction

   function automatic logic [63:0] adr(int q, int s);
      return BASE + 64'(q * DP * RB) + 64'(s * RB);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      @(negedge clk);
      chk("R9 no write", 64'(mem_wr_valid), 0);
      chk("R9 no irq", 64'(eq_irq), 0);
      rd(16'h2600, d); chk("R9 tail zero", d, 0);
      rd(16'h0008, d); chk("R9 entry clear", d, 0);
      rd(16'h2400, d); chk("R9 state clear", d, 0);

      // setup: R10 base, R6 enables, R1 entries
      wr(16'h2A00, BASE);
      rd(16'h2A00, d); chk("R10 base readback", d, BASE);
      wr(16'h2000, EN44); wr(16'h2008, EN44); wr(16'h2010, EN44);
      rd(16'h2008, d); chk("R6 ctl-set reads zero", d, 0);
      rd(16'h2400, d); chk("R6 enable visible", d, EN44);
      wr(16'h0008, V63 | 64'd0);
      wr(16'h0010, V63 | 64'd1);
      wr(16'h0018, V63 | 64'd0);
      wr(16'h0020, V63 | 64'd3);
      wr(16'h0028, 64'd0);
      wr(16'h0030, V63 | 64'd5);
      wr(16'h0038, V63 | 64'd2);
      rd(16'h0038, d); chk("R1 entry readback", d, V63 | 64'd2);

      // table: R2 acceptance, R3 record, R4 pending
      for (int i = 0; i < 8; i++) begin
         send(VEC[i][19:16]);
         if (VEC[i][15]) begin
            chk("R3 write valid", 64'(mem_wr_valid), 1);
            chk("R3 address", mem_wr_addr, adr(int'(VEC[i][14:8]), int'(VEC[i][7:0])));
            chk("R3 data", mem_wr_data, rec(int'(VEC[i][23:16])));
         end else begin
            chk("R2 R4 dropped", 64'(mem_wr_valid), 0);
         end
      end
      rd(16'h2618, d); chk("R2 disabled queue tail unchanged", d, 0);
      chk("R8 irq per queue", 64'(eq_irq), 64'b0111);
      rd(16'h2600, d); chk("R7 tail q0", d, 2);
      rd(16'h0018, d); chk("R4 pending visible", d, V63 | P62);

      // R4 re-arm, then R5 full
      wr(16'h1008, P62);
      send(4'd1);
      chk("R4 rearmed write", 64'(mem_wr_valid), 1);
      chk("R4 rearmed addr", mem_wr_addr, adr(0, 2));
      wr(16'h1008, P62);
      send(4'd1);
      chk("R5 full drop", 64'(mem_wr_valid), 0);
      rd(16'h2400, d); chk("R5 overflow set", d, EN44 | 64'd1);
      rd(16'h0008, d); chk("R5 pending left clear", d, V63);

      // R8 head catch-up, R7 wrap
      wr(16'h2800, 64'd3);
      chk("R8 irq drops when empty", 64'(eq_irq), 64'b0110);
      send(4'd1);
      chk("R7 last slot write", mem_wr_addr, adr(0, 3));
      rd(16'h2600, d); chk("R7 tail wraps", d, 0);
      chk("R8 irq back", 64'(eq_irq), 64'b0111);

      // R5 sticky until cleared
      rd(16'h2400, d); chk("R5 overflow sticky", d, EN44 | 64'd1);
      wr(16'h2200, 64'd1);
      rd(16'h2400, d); chk("R5 overflow cleared", d, EN44);

      // R6 disable
      wr(16'h2208, EN44);
      chk("R6 R8 irq off when disabled", 64'(eq_irq), 64'b0101);
      wr(16'h1010, P62);
      send(4'd2);
      chk("R6 disabled drop", 64'(mem_wr_valid), 0);
      rd(16'h2608, d); chk("R6 tail unchanged", d, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule